// File: doc/BRIEF.md
# Multi-Digit BCD Adder

This block adds two packed decimal numbers, each made of a parameterised count of 4-bit BCD digits, together with a single decimal carry input. The result is a packed BCD sum of the same width and a decimal carry output. Each digit is summed in plain binary, and a small detector then inspects the five-bit raw result. Any raw value above nine is pulled back into the decimal range by adding six, and the digit passes a carry to the next more significant digit.

The digit carries ripple from the least significant digit up to the most significant one within one clock period. The sum and the carry out are captured in a register on the rising clock edge, so the result for inputs presented before an edge appears after that edge. The inputs are expected to hold valid BCD digits (0 to 9). The block does not subtract and does not flag invalid digits.

Top module: `bcd_ripple_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o` becomes all zeros and `carry_o` becomes 0 after that edge.
- R2: `sum_o` and `carry_o` show the result of the `a_i`, `b_i` and `carry_i` values sampled at the most recent rising edge. Input changes between edges do not reach the outputs before the next edge.
- R3: A digit whose raw binary sum (digit of A, plus digit of B, plus the incoming carry) is 9 or less is output unchanged, and that digit sends no carry onward. For example, 0005 + 0004 gives 0009.
- R4: A digit whose raw sum is from 10 to 19 outputs raw minus 10, which is the low four bits of raw plus 6, and sends a carry of 1 to the next digit. Every output digit is therefore in the range 0 to 9 when the inputs are valid BCD.
- R5: `carry_i` is added into the least significant digit (bits 3:0) only. For example, 0000 + 0000 with `carry_i`=1 gives 0001.
- R6: `carry_o` is the decimal carry from the most significant digit. Taken as decimal values, `sum_o` + 10^DIGITS·`carry_o` equals A + B + `carry_i`.
- R7: A carry ripples through any run of digits that sum to 9. For example, 9999 + 0000 with `carry_i`=1 gives `sum_o`=0000 and `carry_o`=1.
- R8: Digit k occupies bits 4k+3:4k of `a_i`, `b_i` and `sum_o`, and digit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a_i | input | 4·DIGITS | First packed BCD operand |
| b_i | input | 4·DIGITS | Second packed BCD operand |
| carry_i | input | 1 | Decimal carry into digit 0 |
| sum_o | output | 4·DIGITS | Registered packed BCD sum |
| carry_o | output | 1 | Registered decimal carry out of the top digit |

## Verification
The hardest case to reach is a correction that is triggered only by a carry arriving from the digit below. Such a carry can travel through every digit, so the final carry out depends on a chain that starts at `carry_i`. The stimulus sets up operands whose digits each sum to exactly nine, such as 9999 + 0000 and 2468 + 7531, and then sets `carry_i`. One input bit then flips every digit through the add-six path. Vectors with raw digit sums of 9, 10 and 19 cover both sides of the detector threshold and its largest value.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int DIGIT_W = 4;
  localparam int RAW_W   = DIGIT_W + 1;
  localparam logic [DIGIT_W-1:0] FIX_ADD = 4'd6;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  typedef logic [RAW_W-1:0]   raw_sum_t;
endpackage

// File: rtl/bcd_fix_detect.sv
module bcd_fix_detect
  import bcd_add_pkg::*;
(
  input  raw_sum_t raw_i,
  output logic     fix_o
);
  // raw above nine: bit4 set, or bit3 set with bit2 or bit1
  always_comb begin
    fix_o = raw_i[4] | (raw_i[3] & (raw_i[2] | raw_i[1]));
  end
endmodule

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
  import bcd_add_pkg::*;
(
  input  bcd_digit_t a_i,
  input  bcd_digit_t b_i,
  input  logic       cin_i,
  output bcd_digit_t digit_o,
  output logic       cout_o
);
  raw_sum_t raw;
  logic     fix;

  always_comb begin
    raw = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
  end

  bcd_fix_detect det_i (
    .raw_i (raw),
    .fix_o (fix)
  );

  // carry of the second addition is dropped; fix alone carries on
  always_comb begin
    digit_o = raw[DIGIT_W-1:0] + (fix ? FIX_ADD : '0);
    cout_o  = fix;
  end
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder
  import bcd_add_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DIGITS*DIGIT_W-1:0] a_i,
  input  logic [DIGITS*DIGIT_W-1:0] b_i,
  input  logic                      carry_i,
  output logic [DIGITS*DIGIT_W-1:0] sum_o,
  output logic                      carry_o
);
  localparam int VEC_W = DIGITS * DIGIT_W;

  logic [DIGITS:0]  chain;
  logic [VEC_W-1:0] sum_comb;

  assign chain[0] = carry_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    bcd_digit_slice slice_i (
      .a_i     (a_i[k*DIGIT_W +: DIGIT_W]),
      .b_i     (b_i[k*DIGIT_W +: DIGIT_W]),
      .cin_i   (chain[k]),
      .digit_o (sum_comb[k*DIGIT_W +: DIGIT_W]),
      .cout_o  (chain[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      sum_o   <= sum_comb;
      carry_o <= chain[DIGITS];
    end
  end
endmodule

// File: rtl/bcd_ripple_adder_chk.sv
module bcd_ripple_adder_chk
  import bcd_add_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [DIGITS*DIGIT_W-1:0] a_i,
  input logic [DIGITS*DIGIT_W-1:0] b_i,
  input logic                      carry_i,
  input logic [DIGITS*DIGIT_W-1:0] sum_o,
  input logic                      carry_o
);
  localparam int VEC_W = DIGITS * DIGIT_W;
  localparam int TOP_LO = VEC_W - DIGIT_W;

  function automatic logic all_bcd(input logic [VEC_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (v[k*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  raw_sum_t top_pair;
  assign top_pair = {1'b0, a_i[TOP_LO +: DIGIT_W]} + {1'b0, b_i[TOP_LO +: DIGIT_W]};

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: reset taken at an edge clears the outputs
  always @(negedge clk) begin
    if (rst_q) p_reset_clear_r1: assert (sum_o == '0 && carry_o == 1'b0);
  end

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(a_i) && $stable(b_i) && $stable(carry_i))
    |=> ($stable(sum_o) && $stable(carry_o)));

  p_zero_in_r3: assert property (@(posedge clk) disable iff (rst)
    (a_i == '0 && b_i == '0 && !carry_i) |=> (sum_o == '0 && !carry_o));

  p_digits_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (all_bcd(a_i) && all_bcd(b_i)) |=> all_bcd(sum_o));

  p_carry_in_lsd_r5: assert property (@(posedge clk) disable iff (rst)
    (a_i == '0 && b_i == '0 && carry_i) |=> (sum_o == VEC_W'(1) && !carry_o));

  p_top_no_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (top_pair <= 5'd8) |=> !carry_o);

  p_top_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (top_pair >= 5'd10) |=> carry_o);
endmodule

bind bcd_ripple_adder bcd_ripple_adder_chk #(.DIGITS(DIGITS)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .a_i     (a_i),
  .b_i     (b_i),
  .carry_i (carry_i),
  .sum_o   (sum_o),
  .carry_o (carry_o)
);

// File: tb/bcd_ripple_adder_tb_top.sv
module bcd_ripple_adder_tb_top;
  localparam int DIGITS = 4;
  localparam int W = DIGITS * 4;
  localparam int N = 13;
  localparam int WRAP = 10000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         carry_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_ripple_adder #(.DIGITS(DIGITS)) dut_i (
    .clk (clk), .rst (rst), .a_i (a_i), .b_i (b_i),
    .carry_i (carry_i), .sum_o (sum_o), .carry_o (carry_o)
  );

  // operand A, operand B (BCD), carry in, expected decimal total
  localparam logic [W-1:0] A_TAB [N] = '{16'h0000, 16'h1234, 16'h0005, 16'h0005,
    16'h0009, 16'h9999, 16'h9999, 16'h5000, 16'h0808, 16'h2468, 16'h0000,
    16'h4567, 16'h0099};
  localparam logic [W-1:0] B_TAB [N] = '{16'h0000, 16'h4321, 16'h0004, 16'h0005,
    16'h0009, 16'h0000, 16'h9999, 16'h5000, 16'h0202, 16'h7531, 16'h0000,
    16'h0089, 16'h0001};
  localparam bit C_TAB [N] = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 1, 1, 0, 0};
  localparam int E_TAB [N] = '{0, 5555, 9, 10, 19, 10000, 19999, 10000, 1010,
    10000, 1, 4656, 100};

  function automatic string tag_of(input int i);
    case (i)
      0:       return "R3";
      2:       return "R3";
      3:       return "R4";
      4:       return "R4";
      5:       return "R7";
      6:       return "R6";
      7:       return "R8";
      9:       return "R7";
      10:      return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    for (int k = 0; k < DIGITS; k++) begin
      r[k*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp_s, input logic exp_c);
    checks++;
    if (sum_o !== exp_s || carry_o !== exp_c) begin
      errors++;
      $display("FAIL %s: sum=%h carry=%b expected sum=%h carry=%b",
               req, sum_o, carry_o, exp_s, exp_c);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(negedge clk);
    a_i = a; b_i = b; carry_i = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      apply(A_TAB[i], B_TAB[i], C_TAB[i]);
      check(tag_of(i), to_bcd(E_TAB[i] % WRAP), E_TAB[i] >= WRAP);
    end

    // R2: a change after the edge stays hidden until the next edge
    apply(16'h1111, 16'h2222, 1'b0);
    a_i = 16'h7777; b_i = 16'h2222; carry_i = 1'b1;
    #1;
    check("R2", 16'h3333, 1'b0);
    @(negedge clk);
    check("R2", 16'h0000, 1'b1);

    // R8: carry into the top digit lands at bits 15:12
    apply(16'h0900, 16'h0100, 1'b0);
    check("R8", 16'h1000, 1'b0);

    // R1: reset while the outputs are non-zero
    apply(16'h9999, 16'h9999, 1'b1);
    check("R6", 16'h9999, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 16'h9999, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule